// File: doc/BRIEF.md
# CAS Signalling Multiframe Aligner

This block finds the 16-frame channel-associated signalling multiframe carried in timeslot 16 of an aligned 2.048 Mbit/s frame stream. Upstream logic hands it the timeslot-16 octet of each frame with a one-cycle frame strobe, plus a flag that says basic frame alignment is held. The block hunts for the all-zero multiframe alignment nibble and reports multiframe sync on an active-low status line. It numbers the frames of the multiframe and raises a freeze control. That control holds the received signalling bits at their last values whenever multiframe alignment is absent.

The aligner locks on the first matching nibble, with no confirmation step. After that it checks only the frame-0 nibble of each multiframe. It tolerates one errored multiframe and drops sync after two in a row. A manual reframe request or a loss of basic frame alignment sends it back to hunting. The block works on its own, in parallel with any CRC-4 multiframe search.

Top module: `cas_mf_aligner`

## Requirements
- R1: While hunting with `bsync` high, the first strobed octet whose bits 7:4 equal 0000 gives alignment at once. `mf_sync_n` goes low at the clock edge that samples that strobe. A strobed octet with any other upper nibble leaves `mf_sync_n` high.
- R2: While `bsync` is low no alignment is taken. `bsync` low while aligned returns the block to hunting at the next clock edge, with `mf_sync_n` high.
- R3: The strobe that gives alignment is frame 0, so `frame_num` reads 0 after that edge. Each later strobe advances `frame_num` by one, and it wraps from 15 to 0. With no strobe, `frame_num` holds.
- R4: While aligned, a multiframe is errored when the octet strobed as frame 0 (the strobe after `frame_num` = 15) has bits 7:4 other than 0000. A single errored multiframe keeps alignment. A correct frame-0 nibble clears the count of consecutive errors.
- R5: A second consecutive errored multiframe removes alignment at the edge that samples its frame-0 strobe.
- R6: `sig_freeze` is high whenever the block is not aligned, including after reset and after any loss, and low while aligned.
- R7: `reframe` high sends the block to hunting at the next edge. A strobe in the same cycle as `reframe` is not a candidate. The next matching strobe afterwards realigns.
- R8: A synchronous active-high `rst` sets `mf_sync_n` = 1, `frame_num` = 0 and `sig_freeze` = 1.
- R9: Bits 3:0 of the octet never affect alignment. Neither do the upper nibbles of frames 1 to 15 of an aligned multiframe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe, `ts16` valid for the current frame |
| ts16 | input | 8 | Timeslot-16 octet of the current frame |
| bsync | input | 1 | Basic frame alignment held (active high) |
| reframe | input | 1 | Manual reframe request |
| mf_sync_n | output | 1 | Multiframe sync status, low when aligned |
| frame_num | output | 4 | Frame number within the multiframe |
| sig_freeze | output | 1 | Freeze control for received signalling bits |

## Verification
All three outputs are registered in the same stage. Any effect of a strobe, a `reframe` pulse or a `bsync` drop is therefore visible one clock edge after the input is sampled, with no further delay. The bench drives each input on the falling edge and holds it for exactly one rising edge. It checks the outputs on the next falling edge, which is the first point where the result of that rising edge is stable. Loss and hold cases are checked at the frame-0 strobe itself, so that a design that acted one multiframe late or early would miscompare there.

// File: rtl/cas_mf_pkg.sv
package cas_mf_pkg;
  typedef enum logic {
    MF_HUNT = 1'b0,
    MF_LOCK = 1'b1
  } mf_state_e;
endpackage

// File: rtl/mfas_match.sv
// Compares the alignment nibble of an octet against the expected pattern.
module mfas_match #(
  parameter int MFAS_W = 4,
  parameter logic [MFAS_W-1:0] PATTERN = '0
) (
  input  logic [MFAS_W-1:0] nibble,
  output logic              hit
);
  always_comb hit = (nibble == PATTERN);
endmodule

// File: rtl/mf_frame_ctr.sv
// Frame position counter within the multiframe.
module mf_frame_ctr #(
  parameter int FRAMES = 16,
  localparam int NUM_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             load_zero,
  output logic [NUM_W-1:0] num,
  output logic             at_last
);
  localparam logic [NUM_W-1:0] LAST = NUM_W'(FRAMES - 1);

  always_comb at_last = (num == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      num <= '0;
    end else if (stb) begin
      if (load_zero || at_last) num <= '0;
      else                      num <= num + 1'b1;
    end
  end
endmodule

// File: rtl/mf_sync_ctl.sv
// Hunt/lock control with consecutive-error loss counting.
module mf_sync_ctl
  import cas_mf_pkg::*;
#(
  parameter int LOSS_LIMIT = 2,
  localparam int ERR_W = $clog2(LOSS_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic hit,
  input  logic bsync,
  input  logic reframe,
  input  logic at_last,
  output logic align_now,
  output logic sync_n,
  output logic freeze
);
  localparam logic [ERR_W-1:0] LAST_ERR = ERR_W'(LOSS_LIMIT - 1);

  mf_state_e        state;
  logic [ERR_W-1:0] errs;

  always_comb align_now = (state == MF_HUNT) && bsync && !reframe && stb && hit;

  always_ff @(posedge clk) begin
    if (rst || !bsync || reframe) begin
      state  <= MF_HUNT;
      errs   <= '0;
      sync_n <= 1'b1;
      freeze <= 1'b1;
    end else if (stb) begin
      unique case (state)
        MF_HUNT: begin
          if (hit) begin
            state  <= MF_LOCK;
            errs   <= '0;
            sync_n <= 1'b0;
            freeze <= 1'b0;
          end
        end
        MF_LOCK: begin
          if (at_last) begin
            if (hit) begin
              errs <= '0;
            end else if (errs == LAST_ERR) begin
              state  <= MF_HUNT;
              errs   <= '0;
              sync_n <= 1'b1;
              freeze <= 1'b1;
            end else begin
              errs <= errs + 1'b1;
            end
          end
        end
        default: state <= MF_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/cas_mf_aligner.sv
module cas_mf_aligner #(
  parameter int OCT_W = 8,
  parameter int MFAS_W = 4,
  parameter logic [MFAS_W-1:0] MFAS_PATTERN = '0,
  parameter int FRAMES = 16,
  parameter int LOSS_LIMIT = 2,
  localparam int NUM_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic [OCT_W-1:0] ts16,
  input  logic             bsync,
  input  logic             reframe,
  output logic             mf_sync_n,
  output logic [NUM_W-1:0] frame_num,
  output logic             sig_freeze
);
  logic hit, at_last, align_now;
  logic unused_low;

  assign unused_low = ^ts16[OCT_W-MFAS_W-1:0];

  mfas_match #(.MFAS_W(MFAS_W), .PATTERN(MFAS_PATTERN)) u_match (
    .nibble (ts16[OCT_W-1 -: MFAS_W]),
    .hit    (hit)
  );

  mf_frame_ctr #(.FRAMES(FRAMES)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .stb       (frame_stb),
    .load_zero (align_now),
    .num       (frame_num),
    .at_last   (at_last)
  );

  mf_sync_ctl #(.LOSS_LIMIT(LOSS_LIMIT)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .stb       (frame_stb),
    .hit       (hit),
    .bsync     (bsync),
    .reframe   (reframe),
    .at_last   (at_last),
    .align_now (align_now),
    .sync_n    (mf_sync_n),
    .freeze    (sig_freeze)
  );
endmodule

// File: rtl/cas_mf_aligner_chk.sv
module cas_mf_aligner_chk #(
  parameter int OCT_W = 8,
  parameter int MFAS_W = 4,
  parameter logic [MFAS_W-1:0] MFAS_PATTERN = '0,
  parameter int FRAMES = 16,
  localparam int NUM_W = $clog2(FRAMES)
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_stb,
  input logic [OCT_W-1:0] ts16,
  input logic             bsync,
  input logic             reframe,
  input logic             mf_sync_n,
  input logic [NUM_W-1:0] frame_num,
  input logic             sig_freeze
);
  localparam logic [NUM_W-1:0] LAST = NUM_W'(FRAMES - 1);

  // R1: a fall of the sync status needs a matching strobe with bsync high
  p_align_on_match_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(mf_sync_n) |-> $past(frame_stb && bsync && !reframe &&
                               ts16[OCT_W-1 -: MFAS_W] == MFAS_PATTERN));

  p_no_sync_without_bsync_r2: assert property (@(posedge clk) disable iff (rst)
    !bsync |=> mf_sync_n);

  p_align_is_frame0_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(mf_sync_n) |-> frame_num == '0);

  p_step_when_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !mf_sync_n) |=>
      frame_num == (($past(frame_num) == LAST) ? '0 : $past(frame_num) + 1'b1));

  p_hold_without_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(frame_num));

  p_loss_at_frame0_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(mf_sync_n) && $past(bsync && !reframe)) |->
      ($past(frame_stb) && $past(frame_num) == LAST &&
       $past(ts16[OCT_W-1 -: MFAS_W]) != MFAS_PATTERN));

  p_freeze_tracks_loss_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mf_sync_n) |-> sig_freeze);

  p_reframe_hunts_r7: assert property (@(posedge clk) disable iff (rst)
    reframe |=> mf_sync_n);

  p_reset_state_r8: assert property (@(posedge clk)
    rst |=> (mf_sync_n && sig_freeze && frame_num == '0));
endmodule

bind cas_mf_aligner cas_mf_aligner_chk #(
  .OCT_W(OCT_W), .MFAS_W(MFAS_W), .MFAS_PATTERN(MFAS_PATTERN), .FRAMES(FRAMES)
) u_chk (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .ts16(ts16), .bsync(bsync),
  .reframe(reframe), .mf_sync_n(mf_sync_n), .frame_num(frame_num),
  .sig_freeze(sig_freeze)
);

// File: tb/cas_mf_aligner_bench.sv
`timescale 1ns/1ps
module cas_mf_aligner_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0;
  logic [7:0] ts16 = 8'h00;
  logic       bsync = 1'b0;
  logic       reframe = 1'b0;
  logic       mf_sync_n;
  logic [3:0] frame_num;
  logic       sig_freeze;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cas_mf_aligner u_cas_mf_aligner (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .ts16(ts16), .bsync(bsync),
    .reframe(reframe), .mf_sync_n(mf_sync_n), .frame_num(frame_num),
    .sig_freeze(sig_freeze)
  );

  task automatic check(string req, logic exp_sync_n, logic [3:0] exp_num, logic exp_frz);
    vectors++;
    if (mf_sync_n !== exp_sync_n || frame_num !== exp_num || sig_freeze !== exp_frz) begin
      errors++;
      $display("FAIL %s: sync_n/num/freeze = %b/%0d/%b, expected %b/%0d/%b",
               req, mf_sync_n, frame_num, sig_freeze, exp_sync_n, exp_num, exp_frz);
    end
  endtask

  // one strobed frame, then one idle cycle; outputs checked on return
  task automatic send(logic [7:0] oct, logic with_reframe = 1'b0);
    frame_stb = 1'b1;
    ts16      = oct;
    reframe   = with_reframe;
    @(negedge clk);
    frame_stb = 1'b0;
    reframe   = 1'b0;
    ts16      = 8'hEE;
    @(negedge clk);
  endtask

  // frames 1..15 of an aligned multiframe, checking the count on each
  task automatic fill(logic [7:0] oct, string req);
    for (int i = 1; i < 16; i++) begin
      send(oct);
      check(req, 1'b0, 4'(i), 1'b0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 reset", 1'b1, 4'd0, 1'b1);
  endtask

  task automatic t_no_bsync();
    bsync = 1'b0;
    send(8'h00);
    check("R2 no bsync", 1'b1, 4'd1, 1'b1);
    send(8'h0F);
    check("R2 no bsync", 1'b1, 4'd2, 1'b1);
  endtask

  task automatic t_align();
    bsync = 1'b1;
    @(negedge clk);
    send(8'h5A);
    check("R1 mismatch", 1'b1, 4'd3, 1'b1);
    send(8'h0B);              // lower nibble nonzero: R9
    check("R1 align", 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_count_wrap();
    fill(8'h00, "R9 upper nibble mid-multiframe");
    send(8'h07);
    check("R3 wrap", 1'b0, 4'd0, 1'b0);
    repeat (3) @(negedge clk);
    check("R3 hold", 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_errors();
    fill(8'hF0, "R3 count");
    send(8'h30);
    check("R4 single error kept", 1'b0, 4'd0, 1'b0);
    fill(8'hF0, "R3 count");
    send(8'h00);
    check("R4 good clears", 1'b0, 4'd0, 1'b0);
    fill(8'hF0, "R3 count");
    send(8'h80);
    check("R4 first error", 1'b0, 4'd0, 1'b0);
    fill(8'hF0, "R3 count");
    send(8'h10);
    check("R5 loss", 1'b1, 4'd0, 1'b1);
    send(8'h50);
    check("R6 frozen while hunting", 1'b1, 4'd1, 1'b1);
  endtask

  task automatic t_reframe();
    send(8'h00);
    check("R1 realign", 1'b0, 4'd0, 1'b0);
    reframe = 1'b1;
    @(negedge clk);
    reframe = 1'b0;
    check("R7 reframe", 1'b1, 4'd0, 1'b1);
    send(8'h00, 1'b1);
    check("R7 strobe with reframe ignored", 1'b1, 4'd1, 1'b1);
    send(8'h0C);
    check("R7 next match aligns", 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_bsync_loss();
    send(8'hF0);
    check("R3 count", 1'b0, 4'd1, 1'b0);
    bsync = 1'b0;
    @(negedge clk);
    check("R2 bsync loss", 1'b1, 4'd1, 1'b1);
    bsync = 1'b1;
    @(negedge clk);
    check("R6 still frozen", 1'b1, 4'd1, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_no_bsync();
    t_align();
    t_count_wrap();
    t_errors();
    t_reframe();
    t_bsync_loss();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule